// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This block monitors a wide set of already-synchronized pin inputs, split into equal-width banks. Each pin can be armed to catch low-to-high transitions, high-to-low transitions, or both. A caught transition sets a sticky status bit. That happens only while the pin's direction bit marks it as an input. Software clears status by writing ones to the bits it wants cleared. The status of every pin is folded into three interrupt lines. Bank 0 bits 0 and 1 each get a line of their own, and all remaining pins share the third line.

A fixed per-pin mask marks which pins can wake the system. While the sleep input is high, any level change on a masked input pin raises a wake request. That request holds until sleep is released. The register decoder sits outside this block. It presents a write strobe, a bank index, a target selector and a data word, and it selects which bank's status word is returned on the readback port.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset all status bits, all rising and falling enables, the three interrupt lines and the wake output are zero.
- R2: When a pin's sampled level goes from 0 in one clock to 1 in the next, its rising-enable bit is 1 and its direction bit is 0 (input), its status bit reads 1 after that second clock edge.
- R3: A 1-to-0 level change sets the status bit in the same way, gated by the falling-enable bit.
- R4: A pin whose direction bit is 1 (output) never sets its status bit, whatever its enables and level changes.
- R5: Status bits are sticky. A transition whose enable is 0 sets nothing, and a set bit stays 1 after the pin returns to its former level.
- R6: A write with selector 2'b10 clears, in the addressed bank, each status bit where the data bit is 1 and leaves bits with data 0 unchanged. Selector 2'b00 loads the rising enables, 2'b01 loads the falling enables, and 2'b11 changes nothing.
- R7: If an enabled transition and a clearing write hit the same status bit in the same clock, the bit ends up 1.
- R8: irq_o[0] equals bank 0 status bit 0, irq_o[1] equals bank 0 status bit 1, and irq_o[2] is the OR of all other status bits.
- R9: While sleep_i is high, a level change on an input pin whose wake-mask bit is set drives wake_o high after that clock edge. The default masks are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F for banks 0 to 3. Unmasked pins and output pins never wake.
- R10: wake_o stays high while sleep_i stays high, and drops after the first clock edge at which sleep_i is low.
- R11: The first clock edge after reset only records the pin levels as a reference, so no status bit or wake request comes from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_BANKS*BANK_W | Synchronized pin levels, bank 0 in the low bits |
| dir_i | input | NUM_BANKS*BANK_W | Per-pin direction, 1 = output, 0 = input |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 00 rising enable, 01 falling enable, 10 status clear, 11 none |
| wr_bank_i | input | BANK_IDX_W | Bank addressed by the write |
| wr_data_i | input | BANK_W | Write data word |
| rd_bank_i | input | BANK_IDX_W | Bank whose status is returned |
| rd_status_o | output | BANK_W | Status word of the selected bank |
| irq_o | output | 3 | Interrupt lines: bank 0 bit 0, bank 0 bit 1, all others |
| sleep_i | input | 1 | System is sleeping |
| wake_o | output | 1 | Wake request |

## Verification
A stale previous-level register or an enable loaded into the wrong bank appears as a status bit that is set, or missing, one clock after the pin change. It shows on the readback of that bank and, for bank 0 low bits, on a dedicated interrupt line in the same cycle. A clear applied to the wrong bits shows as a sticky bit that vanishes, or one that survives, right after the write. A wrong wake mask or a missing hold appears on wake_o one clock after a pin change or after sleep drops. Every one of these shows within one clock of its cause, so the bench compares all banks after every edge.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

   typedef enum logic [1:0] {
      SEL_RISE = 2'b00,
      SEL_FALL = 2'b01,
      SEL_CLR  = 2'b10,
      SEL_NONE = 2'b11
   } wr_sel_e;

   // index width that stays at least one bit wide
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   localparam int IRQ_LINES = 3;

endpackage

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
   parameter int          BANK_W    = 32,
   parameter logic [31:0] WAKE_MASK = 32'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              armed_i,
   input  logic [BANK_W-1:0] pin_i,
   input  logic [BANK_W-1:0] dir_i,
   input  logic              rise_we_i,
   input  logic              fall_we_i,
   input  logic              clr_we_i,
   input  logic [BANK_W-1:0] wr_data_i,
   output logic [BANK_W-1:0] status_o,
   output logic [BANK_W-1:0] clr_o,
   output logic              wake_hit_o
);

   logic [BANK_W-1:0] prev_q;
   logic [BANK_W-1:0] rise_en_q;
   logic [BANK_W-1:0] fall_en_q;
   logic [BANK_W-1:0] status_q;
   logic [BANK_W-1:0] went_up;
   logic [BANK_W-1:0] went_down;
   logic [BANK_W-1:0] set_vec;
   logic [BANK_W-1:0] is_input;
   logic [BANK_W-1:0] wake_sel;

   assign is_input  = ~dir_i;
   assign went_up   = pin_i & ~prev_q;
   assign went_down = ~pin_i & prev_q;
   assign set_vec   = armed_i ? (((went_up & rise_en_q) | (went_down & fall_en_q)) & is_input)
                              : '0;
   assign clr_o     = clr_we_i ? wr_data_i : '0;
   assign wake_sel  = WAKE_MASK[BANK_W-1:0];
   assign wake_hit_o = armed_i & (|((went_up | went_down) & is_input & wake_sel));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q    <= '0;
         rise_en_q <= '0;
         fall_en_q <= '0;
         status_q  <= '0;
      end else begin
         prev_q   <= pin_i;
         // a fresh edge wins over a clear of the same bit
         status_q <= (status_q & ~clr_o) | set_vec;
         if (rise_we_i) rise_en_q <= wr_data_i;
         if (fall_we_i) fall_en_q <= wr_data_i;
      end
   end

   assign status_o = status_q;

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
   parameter int NPIN = 128
) (
   input  logic [NPIN-1:0] status_i,
   output logic [2:0]      irq_o
);

   assign irq_o[0] = status_i[0];
   assign irq_o[1] = status_i[1];
   assign irq_o[2] = |status_i[NPIN-1:2];

endmodule

// File: rtl/gpio_wake_ctl.sv
module gpio_wake_ctl #(
   parameter int NUM_BANKS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_BANKS-1:0] hit_i,
   input  logic                 sleep_i,
   output logic                 wake_o
);

   logic wake_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       wake_q <= 1'b0;
      else if (!sleep_i) wake_q <= 1'b0;
      else if (|hit_i)   wake_q <= 1'b1;
   end

   assign wake_o = wake_q;

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
   parameter int                            NUM_BANKS = 4,
   parameter int                            BANK_W    = 32,
   parameter logic [NUM_BANKS*32-1:0]       WAKE_MASK = {32'h0012007F, 32'hEC080000,
                                                         32'h002001FC, 32'h8003FE1B},
   parameter int                            BANK_IDX_W = gpio_edge_pkg::idx_w(NUM_BANKS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_BANKS*BANK_W-1:0] pin_i,
   input  logic [NUM_BANKS*BANK_W-1:0] dir_i,
   input  logic                        wr_en_i,
   input  logic [1:0]                  wr_sel_i,
   input  logic [BANK_IDX_W-1:0]       wr_bank_i,
   input  logic [BANK_W-1:0]           wr_data_i,
   input  logic [BANK_IDX_W-1:0]       rd_bank_i,
   output logic [BANK_W-1:0]           rd_status_o,
   output logic [2:0]                  irq_o,
   input  logic                        sleep_i,
   output logic                        wake_o
);
   import gpio_edge_pkg::*;

   localparam int NPIN = NUM_BANKS * BANK_W;

   if (BANK_W < 2 || BANK_W > 32) begin : g_bad_width
      $error("BANK_W must lie in 2..32");
   end
   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("NUM_BANKS must be at least 1");
   end
   if (BANK_IDX_W < idx_w(NUM_BANKS)) begin : g_bad_idx
      $error("BANK_IDX_W too narrow for NUM_BANKS");
   end

   wr_sel_e              sel;
   logic                 armed_q;
   logic [NPIN-1:0]      stat_all;
   logic [NPIN-1:0]      clr_all;
   logic [NUM_BANKS-1:0] wake_hits;

   assign sel = wr_sel_e'(wr_sel_i);

   // first edge after reset only captures the reference levels
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= 1'b1;
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit_bank;
      logic rise_we, fall_we, clr_we;
      assign hit_bank = wr_en_i && (wr_bank_i == BANK_IDX_W'(b));
      assign rise_we  = hit_bank && (sel == SEL_RISE);
      assign fall_we  = hit_bank && (sel == SEL_FALL);
      assign clr_we   = hit_bank && (sel == SEL_CLR);

      gpio_edge_bank #(
         .BANK_W    (BANK_W),
         .WAKE_MASK (WAKE_MASK[b*32 +: 32])
      ) i_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .armed_i    (armed_q),
         .pin_i      (pin_i[b*BANK_W +: BANK_W]),
         .dir_i      (dir_i[b*BANK_W +: BANK_W]),
         .rise_we_i  (rise_we),
         .fall_we_i  (fall_we),
         .clr_we_i   (clr_we),
         .wr_data_i  (wr_data_i),
         .status_o   (stat_all[b*BANK_W +: BANK_W]),
         .clr_o      (clr_all[b*BANK_W +: BANK_W]),
         .wake_hit_o (wake_hits[b])
      );
   end

   always_comb begin
      rd_status_o = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (rd_bank_i == BANK_IDX_W'(b)) rd_status_o = stat_all[b*BANK_W +: BANK_W];
      end
   end

   gpio_irq_merge #(.NPIN(NPIN)) i_merge (
      .status_i (stat_all),
      .irq_o    (irq_o)
   );

   gpio_wake_ctl #(.NUM_BANKS(NUM_BANKS)) i_wake (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_i   (wake_hits),
      .sleep_i (sleep_i),
      .wake_o  (wake_o)
   );

endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
   parameter int NPIN = 128
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NPIN-1:0] dir_i,
   input logic [NPIN-1:0] stat_all,
   input logic [NPIN-1:0] clr_all,
   input logic [2:0]      irq_o,
   input logic            sleep_i,
   input logic            wake_o
);

   // R4: no status bit rises on a pin that was an output
   p_no_out_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_all & ~$past(stat_all) & $past(dir_i)) == '0));

   // R6: a status bit only falls where a clear write named it
   p_clear_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((~stat_all & $past(stat_all) & ~$past(clr_all)) == '0));

   // R8: dedicated lines track bank 0 bits 0 and 1
   p_irq_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o[1:0] == stat_all[1:0]));

   // R8: shared line covers every other pin
   p_irq_shared_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o[2] == (|stat_all[NPIN-1:2])));

   // R10: wake held while asleep
   p_wake_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_i && wake_o) |=> wake_o);

   // R10: wake released once awake
   p_wake_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_i) |=> !wake_o);

endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.NPIN(NPIN)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .dir_i    (dir_i),
   .stat_all (stat_all),
   .clr_all  (clr_all),
   .irq_o    (irq_o),
   .sleep_i  (sleep_i),
   .wake_o   (wake_o)
);

// File: tb/test_gpio_edge_irq.sv
module test_gpio_edge_irq;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 4;
   localparam int W  = 32;
   localparam int NP = NB * W;
   localparam logic [31:0] WMASK [NB] = '{32'h8003FE1B, 32'h002001FC, 32'hEC080000, 32'h0012007F};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pin = '0;
   logic [NP-1:0] dir = '0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_sel = 2'b11;
   logic [1:0]    wr_bank = '0;
   logic [W-1:0]  wr_data = '0;
   logic [1:0]    rd_bank = '0;
   logic [W-1:0]  rd_status;
   logic [2:0]    irq;
   logic          sleep = 1'b0;
   logic          wake;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // bench model
   logic [W-1:0] m_stat [NB];
   logic [W-1:0] m_rise [NB];
   logic [W-1:0] m_fall [NB];
   logic [W-1:0] m_prev [NB];
   logic         m_armed;
   logic         m_wake;

   gpio_edge_irq i_gpio_edge_irq (
      .clk(clk), .rst_n(rst_n), .pin_i(pin), .dir_i(dir),
      .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_bank_i(wr_bank), .wr_data_i(wr_data),
      .rd_bank_i(rd_bank), .rd_status_o(rd_status), .irq_o(irq),
      .sleep_i(sleep), .wake_o(wake)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [2:0] exp_irq();
      logic rest = 1'b0;
      rest = |m_stat[0][31:2];
      for (int b = 1; b < NB; b++) rest |= |m_stat[b];
      return {rest, m_stat[0][1], m_stat[0][0]};
   endfunction

   task automatic model_reset();
      for (int b = 0; b < NB; b++) begin
         m_stat[b] = '0; m_rise[b] = '0; m_fall[b] = '0; m_prev[b] = '0;
      end
      m_armed = 0; m_wake = 0;
   endtask

   task automatic model_edge();
      logic hit = 1'b0;
      for (int b = 0; b < NB; b++) begin
         logic [W-1:0] p, d, up, dn, clr;
         p = pin[b*W +: W]; d = dir[b*W +: W];
         up = p & ~m_prev[b]; dn = ~p & m_prev[b];
         clr = (wr_en && wr_sel == 2'b10 && wr_bank == 2'(b)) ? wr_data : '0;
         if (m_armed) begin
            m_stat[b] = (m_stat[b] & ~clr) | (((up & m_rise[b]) | (dn & m_fall[b])) & ~d);
            if (|((up | dn) & ~d & WMASK[b])) hit = 1'b1;
         end else m_stat[b] = m_stat[b] & ~clr;
         if (wr_en && wr_bank == 2'(b) && wr_sel == 2'b00) m_rise[b] = wr_data;
         if (wr_en && wr_bank == 2'(b) && wr_sel == 2'b01) m_fall[b] = wr_data;
         m_prev[b] = p;
      end
      m_wake = sleep ? (m_wake | hit) : 1'b0;
      m_armed = 1;
   endtask

   task automatic compare_all();
      for (int b = 0; b < NB; b++) begin
         rd_bank = 2'(b);
         #1;
         chk("R2 R3 R4 R5 R6 status", rd_status, m_stat[b]);
      end
      chk("R8 irq", {29'd0, irq}, {29'd0, exp_irq()});
      chk("R9 R10 wake", {31'd0, wake}, {31'd0, m_wake});
   endtask

   // inputs already set after a falling edge; run one rising edge
   task automatic step();
      @(posedge clk);
      model_edge();
      compare_all();
      @(negedge clk);
      wr_en = 1'b0;
      wr_sel = 2'b11;
   endtask

   task automatic wr(input logic [1:0] s, input int b, input logic [31:0] d);
      wr_en = 1'b1; wr_sel = s; wr_bank = 2'(b); wr_data = d;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = 32'h5eed_1234;
      void'($urandom(seed));
      model_reset();
      // R11: pin 0 (wake-capable) high and sleep high across reset release
      pin[0] = 1'b1;
      sleep = 1'b1;
      repeat (3) @(negedge clk);
      // R1: reset state
      for (int b = 0; b < NB; b++) begin
         rd_bank = 2'(b); #1;
         chk("R1 status", rd_status, 32'h0);
      end
      chk("R1 irq", {29'd0, irq}, 32'h0);
      chk("R1 wake", {31'd0, wake}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      step();
      chk("R11 no wake on first edge", {31'd0, wake}, 32'h0);
      step();
      chk("R11 still quiet", {31'd0, wake}, 32'h0);

      // R9: masked input pin change while asleep
      pin[0] = 1'b0; step();
      chk("R9 wake raised", {31'd0, wake}, 32'h1);
      // R10: held, then released
      step();
      chk("R10 wake held", {31'd0, wake}, 32'h1);
      sleep = 1'b0; step();
      chk("R10 wake dropped", {31'd0, wake}, 32'h0);
      // R9: unmasked pin (bank 0 bit 2) never wakes
      sleep = 1'b1; pin[2] = 1'b1; step();
      chk("R9 unmasked quiet", {31'd0, wake}, 32'h0);
      // R9: masked pin as output never wakes
      dir[1] = 1'b1; pin[1] = 1'b1; step();
      chk("R9 output quiet", {31'd0, wake}, 32'h0);
      sleep = 1'b0; dir = '0; pin = '0; step();

      // R2: rising enable on bank 0
      wr(2'b00, 0, 32'hFFFF_FFFF); step();
      pin[0] = 1'b1; step();
      chk("R2 irq0 set", {31'd0, irq[0]}, 32'h1);
      // R5: sticky after return, falling disabled
      pin[0] = 1'b0; step();
      chk("R5 sticky", {31'd0, irq[0]}, 32'h1);
      // R6: clear with zeros keeps; with one clears
      wr(2'b10, 0, 32'h0000_0002); step();
      chk("R6 zero keeps", {31'd0, irq[0]}, 32'h1);
      wr(2'b10, 0, 32'h0000_0001); step();
      chk("R6 one clears", {31'd0, irq[0]}, 32'h0);
      // R6: selector 11 changes nothing
      wr(2'b11, 0, 32'h0); step();
      pin[0] = 1'b1; step();
      chk("R6 none keeps enable", {31'd0, irq[0]}, 32'h1);
      // R7: edge and clear in the same cycle
      wr(2'b10, 0, 32'h0000_0002); pin[1] = 1'b1; step();
      chk("R7 edge wins", {31'd0, irq[1]}, 32'h1);
      // R3: falling enable on bank 2
      wr(2'b01, 2, 32'h0000_0100); pin[64+8] = 1'b1; step();
      pin[64+8] = 1'b0; step();
      rd_bank = 2'd2; #1;
      chk("R3 falling sets", rd_status, 32'h0000_0100);
      chk("R8 shared line", {31'd0, irq[2]}, 32'h1);
      // R4: output pin ignored
      @(negedge clk);
      wr(2'b00, 3, 32'hFFFF_FFFF); step();
      dir[96 +: 32] = '1; pin[96 +: 32] = '1; step();
      rd_bank = 2'd3; #1;
      chk("R4 output ignored", rd_status, 32'h0);
      @(negedge clk);
      for (int b = 0; b < NB; b++) begin wr(2'b10, b, '1); step(); end

      // random phase
      for (int i = 0; i < 3000; i++) begin
         if (($urandom % 16) == 0) dir = {$urandom, $urandom, $urandom, $urandom} &
                                         {$urandom, $urandom, $urandom, $urandom};
         pin = pin ^ ({$urandom, $urandom, $urandom, $urandom} &
                      {$urandom, $urandom, $urandom, $urandom} &
                      {$urandom, $urandom, $urandom, $urandom});
         if (($urandom % 20) == 0) sleep = ~sleep;
         if (($urandom % 3) == 0) begin
            wr(2'($urandom), int'($urandom % NB), $urandom);
         end
         step();
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule